// File: doc/BRIEF.md
# Pushbutton Power-Up Sequencer

This block is the control state machine of a small power manager. It decides when two step-down regulators are switched on and off. Its inputs are already-synchronized flags: a valid external supply, a battery that is present, a pushbutton, two hold-on lines driven by the powered system, and one in-regulation flag per regulator. It drives the two regulator enables, a qualified power-good flag, an active-low pushbutton status and an encoded state.

There are three ways to power up. With a battery, a supply that stays valid for a settle period, or a pushbutton press, starts a power-up window. Without a battery, a reset holds the machine in a power-down state for a fixed time and then moves it to hard reset. From hard reset, a valid supply starts power-up on the next cycle. During the power-up window regulator 1 starts first and regulator 2 follows after a gap. A parameter instead starts both together. The system must claim each regulator through its hold-on line before the window closes. After that, dropping a hold-on line turns its regulator off. When both regulators are off the machine returns to the off state.

All durations are parameters counted in clock cycles, so a bench can shrink them. Reset is synchronous and active-high.

Top module: `pbseq_top`

## Requirements
- R1: While `rst` is high, at each clock edge the state becomes POFF if `bat_ok` is high and PDN1 if it is low. At the same time `reg_en` is 0, `pwr_good` is 0 and `pb_stat_n` is 1. The state codes on `state_code` are POFF=0, HR=1, PDN1=2, PUP1=3, PUP2=4, PON=5.
- R2: In POFF or HR with `bat_ok` high, PUP1 is entered at the SETTLE_CYC-th consecutive edge at which `bus_ok` is high. Any edge with `bus_ok` low restarts the count.
- R3: On entry to PUP1, `reg_en` is 2'b01 (bit 0 is regulator 1). It becomes 2'b11, with the state moving to PUP2, GAP_CYC edges later. When SIMUL_START is 1, `reg_en` is 2'b11 from entry.
- R4: HOLD_CYC edges after PUP1 entry, `reg_en` takes the value of `hold_on` (bit i for regulator i) and the state becomes PON. In PON, a `hold_on` bit that is low at an edge clears its enable, and that enable never comes back on within PON.
- R5: `pwr_good` rises only after PG_CYC consecutive edges at which some enable is on and every enabled regulator has its `in_reg` bit high. The `in_reg` bit of a disabled regulator is ignored.
- R6: A single edge at which an enabled regulator's `in_reg` is low clears `pwr_good` at that edge and restarts the count from zero.
- R7: In PDN1 the enables stay off, and the state moves to HR PDN_CYC edges after reset is released.
- R8: In HR with `bat_ok` low and `bus_ok` high, the next edge enters PUP1 with no settle wait.
- R9: `pb_stat_n` goes low one edge after `pb` is sampled high in PUP1, PUP2 or PON. It does not go low for a press that started in POFF or HR, for as long as that press is held.
- R10: When both enables end up off, whether at the window close or in PON, the state becomes POFF at that same edge and `pwr_good` is 0.
- R11: In POFF or HR with `bat_ok` high, `pb` sampled high enters PUP1 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ok | input | 1 | External supply is valid |
| bat_ok | input | 1 | Battery is present |
| pb | input | 1 | Pushbutton pressed (high) |
| hold_on | input | 2 | Per-regulator hold-on request from the system |
| in_reg | input | 2 | Per-regulator output-in-regulation flag |
| reg_en | output | 2 | Regulator enables, bit 0 is regulator 1 |
| pwr_good | output | 1 | Qualified power-good |
| pb_stat_n | output | 1 | Pushbutton status, low while a later press is held |
| state_code | output | 3 | Encoded state |

## Verification
State and enables react to inputs sampled at one edge and show the result right after that edge. The bench therefore drives inputs just after an edge and checks the outputs just after the next one. Timed transitions (settle, gap, hold window, power-down) are checked one edge before they are due and again at the due edge, so an off-by-one in either direction is caught. Power-good is due at the PG_CYC-th qualifying edge and falls at the first failing edge. It is checked both with directed drops and, under random in-regulation patterns, cycle by cycle against a bench model. Pushbutton status is due one edge after the press is sampled.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;

    localparam int NREG = 2;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_HRST  = 3'd1,
        ST_PDN   = 3'd2,
        ST_UP1   = 3'd3,
        ST_UP2   = 3'd4,
        ST_ON    = 3'd5
    } seq_state_t;

    typedef logic [NREG-1:0] rail_vec_t;

    function automatic logic is_powered(seq_state_t s);
        return (s == ST_UP1) || (s == ST_UP2) || (s == ST_ON);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pbseq_fsm.sv
module pbseq_fsm
    import pbseq_pkg::*;
#(
    parameter int unsigned SETTLE_CYC  = 10,
    parameter int unsigned GAP_CYC     = 4,
    parameter int unsigned HOLD_CYC    = 40,
    parameter int unsigned PDN_CYC     = 20,
    parameter bit          SIMUL_START = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_ok,
    input  logic       bat_ok,
    input  logic       pb,
    input  rail_vec_t  hold_on,
    output seq_state_t st,
    output rail_vec_t  en,
    output rail_vec_t  en_next
);

    localparam int unsigned PH_MAX = max3(SETTLE_CYC, HOLD_CYC, PDN_CYC);
    localparam int unsigned PHW    = $clog2(PH_MAX + 1);
    localparam logic [PHW-1:0] SETTLE_LAST = PHW'(SETTLE_CYC - 1);
    localparam logic [PHW-1:0] GAP_LAST    = PHW'(GAP_CYC - 1);
    localparam logic [PHW-1:0] HOLD_LAST   = PHW'(HOLD_CYC - 1);
    localparam logic [PHW-1:0] PDN_LAST    = PHW'(PDN_CYC - 1);
    localparam rail_vec_t      START_EN    = SIMUL_START ? 2'b11 : 2'b01;

    seq_state_t     st_nxt;
    logic [PHW-1:0] ph, ph_nxt;
    logic           go_up;

    always_comb begin
        st_nxt  = st;
        ph_nxt  = ph + 1'b1;
        en_next = en;
        go_up   = 1'b0;
        unique case (st)
            ST_PDN: begin
                en_next = '0;
                if (ph == PDN_LAST) begin
                    st_nxt = ST_HRST;
                    ph_nxt = '0;
                end
            end
            ST_OFF, ST_HRST: begin
                en_next = '0;
                if (st == ST_HRST && !bat_ok && bus_ok)
                    go_up = 1'b1;
                else if (bat_ok && pb)
                    go_up = 1'b1;
                else if (bat_ok && bus_ok) begin
                    if (ph == SETTLE_LAST) go_up = 1'b1;
                end else
                    ph_nxt = '0;
                if (go_up) begin
                    st_nxt  = ST_UP1;
                    ph_nxt  = '0;
                    en_next = START_EN;
                end
            end
            ST_UP1, ST_UP2: begin
                if (st == ST_UP1 && (SIMUL_START || ph == GAP_LAST)) begin
                    st_nxt  = ST_UP2;
                    en_next = 2'b11;
                end
                if (ph == HOLD_LAST) begin
                    en_next = hold_on;
                    st_nxt  = (hold_on == '0) ? ST_OFF : ST_ON;
                    ph_nxt  = '0;
                end
            end
            ST_ON: begin
                ph_nxt  = '0;
                en_next = en & hold_on;
                if (en_next == '0) st_nxt = ST_OFF;
            end
            default: begin
                st_nxt  = ST_OFF;
                ph_nxt  = '0;
                en_next = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= bat_ok ? ST_OFF : ST_PDN;
            ph <= '0;
            en <= '0;
        end else begin
            st <= st_nxt;
            ph <= ph_nxt;
            en <= en_next;
        end
    end

    AST_SEQ_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!SIMUL_START && st == ST_UP1) |-> en == 2'b01);                 // R3
    AST_SIMUL_BOTH: assert property (@(posedge clk) disable iff (rst)
        (SIMUL_START && (st == ST_UP1 || st == ST_UP2)) |-> en == 2'b11); // R3
    AST_ON_NO_REENABLE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ON && $past(st) == ST_ON) |-> ((en & ~$past(en)) == '0)); // R4
    AST_PDN_QUIET: assert property (@(posedge clk) disable iff (rst)
        st == ST_PDN |-> en == '0);                                       // R7
    AST_HR_FAST_UP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HRST && !bat_ok && bus_ok) |=> st == ST_UP1);           // R8
    AST_PB_START: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_OFF || st == ST_HRST) && bat_ok && pb) |=> st == ST_UP1); // R11

endmodule

// File: rtl/pbseq_pgood.sv
module pbseq_pgood
    import pbseq_pkg::*;
#(
    parameter int unsigned PG_CYC = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  rail_vec_t en_next,
    input  rail_vec_t in_reg,
    output logic      pwr_good
);

    localparam int unsigned CW = $clog2(PG_CYC + 1);
    localparam logic [CW-1:0] PG_LAST = CW'(PG_CYC - 1);

    rail_vec_t     rail_ok;
    logic          qual;
    logic [CW-1:0] cnt;

    for (genvar i = 0; i < NREG; i++) begin : g_rail
        assign rail_ok[i] = !en_next[i] || in_reg[i];
    end

    assign qual = (en_next != '0) && (&rail_ok);

    always_ff @(posedge clk) begin
        if (rst || !qual) begin
            cnt      <= '0;
            pwr_good <= 1'b0;
        end else if (cnt == PG_LAST) begin
            pwr_good <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_PG_DROP: assert property (@(posedge clk) disable iff (rst)
        !qual |=> !pwr_good);                      // R6
    AST_PG_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_good) |-> $past(qual));          // R5

endmodule

// File: rtl/pbseq_pbstat.sv
module pbseq_pbstat (
    input  logic clk,
    input  logic rst,
    input  logic powered,
    input  logic pb,
    output logic pb_stat_n
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            pb_stat_n <= 1'b1;
        end else begin
            armed     <= powered && (armed || !pb);
            pb_stat_n <= !(powered && armed && pb);
        end
    end

    AST_PBSTAT_NEEDS_PRESS: assert property (@(posedge clk) disable iff (rst)
        $fell(pb_stat_n) |-> $past(pb));           // R9

endmodule

// File: rtl/pbseq_top.sv
module pbseq_top
    import pbseq_pkg::*;
#(
    parameter int unsigned SETTLE_CYC  = 10_000_000,
    parameter int unsigned GAP_CYC     = 1_000,
    parameter int unsigned HOLD_CYC    = 500_000_000,
    parameter int unsigned PG_CYC      = 23_000_000,
    parameter int unsigned PDN_CYC     = 100_000_000,
    parameter bit          SIMUL_START = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_ok,
    input  logic       bat_ok,
    input  logic       pb,
    input  logic [1:0] hold_on,
    input  logic [1:0] in_reg,
    output logic [1:0] reg_en,
    output logic       pwr_good,
    output logic       pb_stat_n,
    output logic [2:0] state_code
);

    seq_state_t st;
    rail_vec_t  en, en_next;

    pbseq_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .GAP_CYC    (GAP_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .PDN_CYC    (PDN_CYC),
        .SIMUL_START(SIMUL_START)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .bus_ok (bus_ok),
        .bat_ok (bat_ok),
        .pb     (pb),
        .hold_on(hold_on),
        .st     (st),
        .en     (en),
        .en_next(en_next)
    );

    pbseq_pgood #(.PG_CYC(PG_CYC)) u_pgood (
        .clk     (clk),
        .rst     (rst),
        .en_next (en_next),
        .in_reg  (in_reg),
        .pwr_good(pwr_good)
    );

    pbseq_pbstat u_pbstat (
        .clk      (clk),
        .rst      (rst),
        .powered  (is_powered(st)),
        .pb       (pb),
        .pb_stat_n(pb_stat_n)
    );

    assign reg_en     = en;
    assign state_code = st;

    AST_OFF_ALL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        st == ST_OFF |-> (reg_en == '0 && !pwr_good));          // R10
    AST_PG_ONLY_POWERED: assert property (@(posedge clk) disable iff (rst)
        pwr_good |-> (reg_en != '0));                           // R5

endmodule

// File: tb/tb_pbseq_top.sv
module tb_pbseq_top;

    localparam int SETTLE = 20;
    localparam int GAP    = 5;
    localparam int HOLD   = 60;
    localparam int PG     = 15;
    localparam int PDN    = 30;

    logic       clk = 1'b0;
    logic       rst, bus_ok, bat_ok, pb;
    logic [1:0] hold_on, in_reg;
    logic [1:0] reg_en, reg_en_s;
    logic       pwr_good, pwr_good_s, pb_stat_n, pb_stat_n_s;
    logic [2:0] state_code, state_code_s;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pbseq_top #(.SETTLE_CYC(SETTLE), .GAP_CYC(GAP), .HOLD_CYC(HOLD), .PG_CYC(PG),
                .PDN_CYC(PDN), .SIMUL_START(1'b0)) dut (
        .clk(clk), .rst(rst), .bus_ok(bus_ok), .bat_ok(bat_ok), .pb(pb),
        .hold_on(hold_on), .in_reg(in_reg), .reg_en(reg_en), .pwr_good(pwr_good),
        .pb_stat_n(pb_stat_n), .state_code(state_code));

    pbseq_top #(.SETTLE_CYC(SETTLE), .GAP_CYC(GAP), .HOLD_CYC(HOLD), .PG_CYC(PG),
                .PDN_CYC(PDN), .SIMUL_START(1'b1)) dut_sim (
        .clk(clk), .rst(rst), .bus_ok(bus_ok), .bat_ok(bat_ok), .pb(pb),
        .hold_on(hold_on), .in_reg(in_reg), .reg_en(reg_en_s), .pwr_good(pwr_good_s),
        .pb_stat_n(pb_stat_n_s), .state_code(state_code_s));

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected power-good model: count of consecutive qualifying edges
    int mcnt;
    bit mpg;
    function automatic bit pg_qual(input logic [1:0] en, input logic [1:0] ir);
        return (en != 2'b00) && ((ir & en) == en);
    endfunction

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd20240517);
        rst = 1'b1; bus_ok = 1'b0; bat_ok = 1'b0; pb = 1'b0;
        hold_on = 2'b00; in_reg = 2'b00;
        tick(); tick();
        // reset without battery
        chk("R1", "state", state_code, 2);
        chk("R1", "reg_en", reg_en, 0);
        chk("R1", "pwr_good", pwr_good, 0);
        chk("R1", "pb_stat_n", pb_stat_n, 1);
        rst = 1'b0;
        repeat (PDN - 1) tick();
        chk("R7", "still PDN1", state_code, 2);
        chk("R7", "enables off", reg_en, 0);
        tick();
        chk("R7", "HR after delay", state_code, 1);
        bus_ok = 1'b1;
        tick();
        chk("R8", "fast PUP1", state_code, 3);
        chk("R3", "seq start en", reg_en, 1);
        chk("R3", "simul start en", reg_en_s, 3);
        repeat (GAP - 1) tick();
        chk("R3", "before gap", reg_en, 1);
        tick();
        chk("R3", "PUP2 state", state_code, 4);
        chk("R3", "both on", reg_en, 3);
        hold_on = 2'b01;
        repeat (HOLD - 1 - GAP) tick();
        chk("R4", "window open state", state_code, 4);
        chk("R4", "window open en", reg_en, 3);
        tick();
        chk("R4", "PON state", state_code, 5);
        chk("R4", "claimed en", reg_en, 1);
        chk("R4", "simul claimed en", reg_en_s, 1);
        // power-good, rail 2 disabled so its flag is ignored
        in_reg = 2'b01;
        repeat (PG - 1) tick();
        chk("R5", "pg not yet", pwr_good, 0);
        tick();
        chk("R5", "pg qualified", pwr_good, 1);
        in_reg = 2'b00;
        tick();
        chk("R6", "pg drop", pwr_good, 0);
        in_reg = 2'b01;
        repeat (PG - 1) tick();
        chk("R6", "pg restart count", pwr_good, 0);
        tick();
        chk("R6", "pg requalified", pwr_good, 1);
        // later press while powered
        pb = 1'b1;
        tick();
        chk("R9", "later press low", pb_stat_n, 0);
        pb = 1'b0;
        tick();
        chk("R9", "release high", pb_stat_n, 1);
        chk("R9", "press no state change", state_code, 5);
        hold_on = 2'b00;
        tick();
        chk("R10", "off state", state_code, 0);
        chk("R10", "off en", reg_en, 0);
        chk("R10", "off pg", pwr_good, 0);

        // battery present: settle with a glitch
        bat_ok = 1'b1; bus_ok = 1'b0; in_reg = 2'b00;
        tick();
        bus_ok = 1'b1;
        repeat (5) tick();
        bus_ok = 1'b0;
        tick();
        chk("R2", "glitch stays off", state_code, 0);
        bus_ok = 1'b1;
        repeat (SETTLE - 1) tick();
        chk("R2", "settle not done", state_code, 0);
        tick();
        chk("R2", "settle done", state_code, 3);
        hold_on = 2'b11;
        repeat (HOLD) tick();
        chk("R4", "both claimed state", state_code, 5);
        chk("R4", "both claimed en", reg_en, 3);
        // random in-regulation patterns against the model
        mcnt = 0; mpg = 1'b0;
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            r = $urandom % 8;
            in_reg = (r == 0) ? 2'($urandom % 3) : 2'b11;
            if (!pg_qual(2'b11, in_reg)) begin
                mcnt = 0; mpg = 1'b0;
            end else if (mcnt == PG - 1) begin
                mpg = 1'b1;
            end else begin
                mcnt++;
            end
            tick();
            chk("R5/R6", "random pg", pwr_good, mpg);
        end
        in_reg = 2'b11;
        hold_on = 2'b10;
        tick();
        chk("R4", "later drop rail1", reg_en, 2);
        hold_on = 2'b11;
        tick();
        chk("R4", "no re-enable", reg_en, 2);
        hold_on = 2'b00;
        tick();
        chk("R10", "last drop off", state_code, 0);
        chk("R10", "last drop pg", pwr_good, 0);

        // pushbutton start, first press held
        bus_ok = 1'b0; in_reg = 2'b00; pb = 1'b1;
        tick();
        chk("R11", "pb start", state_code, 3);
        chk("R9", "first press high", pb_stat_n, 1);
        repeat (3) tick();
        chk("R9", "first press held high", pb_stat_n, 1);
        pb = 1'b0;
        tick();
        pb = 1'b1;
        tick();
        chk("R9", "second press low", pb_stat_n, 0);
        pb = 1'b0;
        repeat (HOLD - 6) tick();
        chk("R4", "window still open", state_code, 4);
        tick();
        chk("R10", "unclaimed window off", state_code, 0);
        chk("R10", "unclaimed en", reg_en, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule